// File: doc/BRIEF.md
# Serial-Bus Channel Status Tracker

This block keeps the sticky status word of one logical channel on a framed serial bus. It samples command bytes that a transmitter puts on the bus and status bytes that a receiver returns, plus the push and pop strobes and the full and empty flags of the channel buffer. It also takes a host-side bus error and a loss-of-frame-sync flag. Each status bit is set only when the event makes sense for the configured channel type and direction. An RX channel also tracks whether it is inside a packet, so that a second start command can be flagged.

Software reads `status`, clears bits by writing ones through `clr_we`/`clr_bits`, and enables interrupts per bit through `irq_mask`. The host-error bit drives the interrupt whatever its mask bit holds. The interrupt output is registered.

Status bit positions: 0 buffer error, 1 host error, 2 frame-sync lost, 3 packet abort, 4 packet start, 5 protocol error, 6 break detected. Channel type: 0 synchronous, 1 isochronous, 2 asynchronous, 3 control. `cfg_tx` = 1 selects a TX channel and 0 an RX channel. Command codes: 0x20 async start, 0x26 async break, 0x30 control start, 0x36 control break. Receiver codes: 0x70 break, 0x72 protocol error. Any other byte is data and is ignored.

Top module: `chan_status_tracker`

## Requirements
- R1: After reset, `status`, `in_packet` and `irq` are all 0.
- R2: Bit 0 is set when `cfg_flow_en` = 0 and either a TX channel pops while `buf_empty` = 1, or an RX channel pushes while `buf_full` = 1. With `cfg_flow_en` = 1 it is never set.
- R3: `host_err` sets bit 1 for any configuration. A set bit 1 drives `irq` high even when `irq_mask[1]` = 0.
- R4: `sync_lost` sets bit 2 only when `cfg_type` = 0.
- R5: On an RX channel of type 2 or 3, a start command of the same family (0x20 for type 2, 0x30 for type 3) sets bit 4. Command bytes have no effect on a TX channel.
- R6: On an RX channel of type 2 or 3, bit 3 is set by a same-family break command (0x26 or 0x36), by a receiver byte 0x70, or by `xmit_perr`.
- R7: Bit 5 is set in three cases: a TX channel of type 2 or 3 sees receiver byte 0x72; an RX channel sees any of the four command codes outside its family (every code counts on types 0 and 1); an RX channel sees a valid start while `in_packet` = 1.
- R8: Bit 6 is set for any channel type when a TX channel sees receiver byte 0x70, or when an RX channel sees command 0x26 or 0x36.
- R9: `in_packet` is set by a valid RX start. It is cleared by a valid break, a receiver 0x70 on an RX channel, `xmit_perr`, or `eop`. A start in the same cycle as a clearing event wins, and a start while already in a packet keeps `in_packet` at 1.
- R10: Status bits are sticky. Each bit clears when `clr_we` = 1 with a 1 in `clr_bits` at that position. A set event in the same cycle as its clear leaves the bit at 1.
- R11: `irq` is registered. It equals the OR of (`status` AND `irq_mask`), ORed with status bit 1, taken from the previous cycle's status. A status bit set at edge k therefore raises `irq` at edge k+1.
- R12: Each status bit changes at the clock edge that samples its event, and `in_packet` changes at the edge that samples the start or clearing event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_type | input | 2 | Channel type: 0 sync, 1 iso, 2 async, 3 control |
| cfg_tx | input | 1 | 1 = TX channel, 0 = RX channel |
| cfg_flow_en | input | 1 | Flow-control enable; 0 qualifies the buffer error |
| cmd_valid | input | 1 | `cmd_byte` holds a transmitter command byte this cycle |
| cmd_byte | input | 8 | Transmitter command byte |
| rsp_valid | input | 1 | `rsp_byte` holds a receiver status byte this cycle |
| rsp_byte | input | 8 | Receiver status byte |
| eop | input | 1 | End-of-packet strobe |
| buf_push | input | 1 | Push strobe on the channel buffer |
| buf_pop | input | 1 | Pop strobe on the channel buffer |
| buf_full | input | 1 | Channel buffer is full |
| buf_empty | input | 1 | Channel buffer is empty |
| host_err | input | 1 | Host-side bus error |
| sync_lost | input | 1 | Loss of frame synchronisation |
| xmit_perr | input | 1 | Transmit command protocol error detected |
| clr_we | input | 1 | Write strobe for clearing status |
| clr_bits | input | 7 | Ones clear the matching status bits |
| irq_mask | input | 7 | Per-bit interrupt enable (1 = enabled) |
| status | output | 7 | Sticky status word |
| in_packet | output | 1 | RX channel is inside a packet |
| irq | output | 1 | Registered interrupt |

## Verification
The hardest situation to reach is a start command that arrives while a packet is already open. That is the only case where `in_packet` decides whether a protocol error is raised. The stimulus first opens a packet with a valid start, then sends a second start and checks for the protocol-error bit. It then closes the packet in turn by end-of-packet, by a break command and by a receiver break, and checks that a following start no longer raises the error. A vector table covers the type and direction qualification of every bit. Directed sequences cover a clear that collides with a set, and the one-cycle lag of the interrupt behind the status word.

// File: rtl/chst_pkg.sv
// Package: shared constants and types for the channel status tracker.
// Assumes an 8-bit code width on the bus and the 7-bit status layout below.
package chst_pkg;

    localparam int CODE_W = 8;
    localparam int NSTAT  = 7;

    // status bit positions
    localparam int B_BUF   = 0;
    localparam int B_HOST  = 1;
    localparam int B_SYNC  = 2;
    localparam int B_ABORT = 3;
    localparam int B_START = 4;
    localparam int B_PROTO = 5;
    localparam int B_BRK   = 6;

    // command and response codes
    localparam logic [CODE_W-1:0] C_ASYNC_START = 8'h20;
    localparam logic [CODE_W-1:0] C_ASYNC_BRK   = 8'h26;
    localparam logic [CODE_W-1:0] C_CTRL_START  = 8'h30;
    localparam logic [CODE_W-1:0] C_CTRL_BRK    = 8'h36;
    localparam logic [CODE_W-1:0] R_RX_BRK      = 8'h70;
    localparam logic [CODE_W-1:0] R_RX_PERR     = 8'h72;

    typedef enum logic [1:0] {
        CT_SYNC  = 2'd0,
        CT_ISO   = 2'd1,
        CT_ASYNC = 2'd2,
        CT_CTRL  = 2'd3
    } chan_type_e;

    // decoded bus events for one cycle
    typedef struct packed {
        logic start_ok;   // RX start of the channel's own family
        logic brk_ok;     // RX break of the channel's own family
        logic brk_any;    // RX break of either family
        logic cmd_bad;    // RX command outside the channel's family
        logic rbrk_rx;    // receiver break on an RX packet channel
        logic rbrk_tx;    // receiver break on a TX channel
        logic rperr_tx;   // receiver protocol error on a TX packet channel
        logic xperr_rx;   // transmit protocol error on an RX packet channel
    } bus_ev_t;

endpackage

// File: rtl/chst_decode.sv
// Module: chst_decode
// Purely combinational classification of the command and response bytes
// against the configured channel type and direction.
// Assumes the inputs are valid for the current cycle only.
module chst_decode
    import chst_pkg::*;
#(
    parameter int W = CODE_W
) (
    input  logic [1:0]   cfg_type,
    input  logic         cfg_tx,
    input  logic         cmd_valid,
    input  logic [W-1:0] cmd_byte,
    input  logic         rsp_valid,
    input  logic [W-1:0] rsp_byte,
    input  logic         xmit_perr,
    output bus_ev_t      ev
);

    logic is_rx;
    logic pkt_type;
    logic c_astart, c_abrk, c_cstart, c_cbrk;
    logic fam_ok;
    logic any_start, any_brk;

    // one-hot recognition of the command codes
    always_comb begin
        c_astart = cmd_valid && (cmd_byte == C_ASYNC_START);
        c_abrk   = cmd_valid && (cmd_byte == C_ASYNC_BRK);
        c_cstart = cmd_valid && (cmd_byte == C_CTRL_START);
        c_cbrk   = cmd_valid && (cmd_byte == C_CTRL_BRK);
    end

    // family check and event classification
    always_comb begin
        is_rx     = !cfg_tx;
        pkt_type  = (cfg_type == CT_ASYNC) || (cfg_type == CT_CTRL);
        any_start = c_astart || c_cstart;
        any_brk   = c_abrk || c_cbrk;
        fam_ok    = ((c_astart || c_abrk) && (cfg_type == CT_ASYNC)) ||
                    ((c_cstart || c_cbrk) && (cfg_type == CT_CTRL));

        ev.start_ok = is_rx && any_start && fam_ok;
        ev.brk_ok   = is_rx && any_brk && fam_ok;
        ev.brk_any  = is_rx && any_brk;
        ev.cmd_bad  = is_rx && (any_start || any_brk) && !fam_ok;
        ev.rbrk_rx  = is_rx && pkt_type && rsp_valid && (rsp_byte == R_RX_BRK);
        ev.rbrk_tx  = cfg_tx && rsp_valid && (rsp_byte == R_RX_BRK);
        ev.rperr_tx = cfg_tx && pkt_type && rsp_valid && (rsp_byte == R_RX_PERR);
        ev.xperr_rx = is_rx && pkt_type && xmit_perr;
    end

endmodule

// File: rtl/chst_pkt_track.sv
// Module: chst_pkt_track
// Holds the RX in-packet flag and flags a start that arrives inside an open packet.
// Assumes start and end qualifiers are already gated by type and direction.
module chst_pkt_track (
    input  logic clk,
    input  logic rst_n,
    input  logic start_ok,
    input  logic end_ev,
    output logic in_pkt,
    output logic restart_err
);

    // a start inside an open packet is a protocol violation
    always_comb begin
        restart_err = start_ok && in_pkt;
    end

    // in-packet flag: start wins over any closing event
    always_ff @(posedge clk) begin
        if (!rst_n)        in_pkt <= 1'b0;
        else if (start_ok) in_pkt <= 1'b1;
        else if (end_ev)   in_pkt <= 1'b0;
    end

endmodule

// File: rtl/chst_status_bank.sv
// Module: chst_status_bank
// Sticky status bits with write-one-to-clear and a registered interrupt.
// Bits named in NOMASK raise the interrupt whatever their mask holds.
// Assumes set takes priority over clear in the same cycle.
module chst_status_bank #(
    parameter int                N      = 7,
    parameter logic [N-1:0]      NOMASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_bits,
    input  logic         clr_we,
    input  logic [N-1:0] clr_bits,
    input  logic [N-1:0] mask,
    output logic [N-1:0] status,
    output logic         irq
);

    logic [N-1:0] clr_eff;
    logic [N-1:0] live;

    // clear vector only when the write strobe is active
    always_comb begin
        clr_eff = clr_we ? clr_bits : '0;
    end

    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_bit
            // one sticky bit: set dominates clear
            always_ff @(posedge clk) begin
                if (!rst_n)             status[gi] <= 1'b0;
                else if (set_bits[gi])  status[gi] <= 1'b1;
                else if (clr_eff[gi])   status[gi] <= 1'b0;
            end
            // per-bit interrupt contribution
            always_comb begin
                live[gi] = status[gi] && (mask[gi] || NOMASK[gi]);
            end
        end
    endgenerate

    // registered interrupt from the current status word
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |live;
    end

endmodule

// File: rtl/chan_status_tracker.sv
// Module: chan_status_tracker (top)
// Per-channel status tracker for a framed serial bus. Decodes bus bytes,
// tracks RX packet state, qualifies each status event by channel type and
// direction, and feeds a sticky status bank with one interrupt output.
// Assumes all inputs are synchronous to clk.
module chan_status_tracker
    import chst_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_type,
    input  logic              cfg_tx,
    input  logic              cfg_flow_en,
    input  logic              cmd_valid,
    input  logic [CODE_W-1:0] cmd_byte,
    input  logic              rsp_valid,
    input  logic [CODE_W-1:0] rsp_byte,
    input  logic              eop,
    input  logic              buf_push,
    input  logic              buf_pop,
    input  logic              buf_full,
    input  logic              buf_empty,
    input  logic              host_err,
    input  logic              sync_lost,
    input  logic              xmit_perr,
    input  logic              clr_we,
    input  logic [NSTAT-1:0]  clr_bits,
    input  logic [NSTAT-1:0]  irq_mask,
    output logic [NSTAT-1:0]  status,
    output logic              in_packet,
    output logic              irq
);

    localparam logic [NSTAT-1:0] NOMASK = NSTAT'(1) << B_HOST;

    bus_ev_t          ev;
    logic             restart_err;
    logic             pkt_end;
    logic [NSTAT-1:0] set_bits;

    chst_decode #(.W(CODE_W)) i_decode (
        .cfg_type  (cfg_type),
        .cfg_tx    (cfg_tx),
        .cmd_valid (cmd_valid),
        .cmd_byte  (cmd_byte),
        .rsp_valid (rsp_valid),
        .rsp_byte  (rsp_byte),
        .xmit_perr (xmit_perr),
        .ev        (ev)
    );

    // events that close an open RX packet
    always_comb begin
        pkt_end = ev.brk_ok || ev.rbrk_rx || ev.xperr_rx || eop;
    end

    chst_pkt_track i_pkt (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_ok    (ev.start_ok),
        .end_ev      (pkt_end),
        .in_pkt      (in_packet),
        .restart_err (restart_err)
    );

    // qualified set vector for every status bit
    always_comb begin
        set_bits          = '0;
        set_bits[B_BUF]   = !cfg_flow_en &&
                            ((cfg_tx && buf_pop && buf_empty) ||
                             (!cfg_tx && buf_push && buf_full));
        set_bits[B_HOST]  = host_err;
        set_bits[B_SYNC]  = sync_lost && (cfg_type == CT_SYNC);
        set_bits[B_ABORT] = ev.brk_ok || ev.rbrk_rx || ev.xperr_rx;
        set_bits[B_START] = ev.start_ok;
        set_bits[B_PROTO] = ev.rperr_tx || ev.cmd_bad || restart_err;
        set_bits[B_BRK]   = ev.rbrk_tx || ev.brk_any;
    end

    chst_status_bank #(.N(NSTAT), .NOMASK(NOMASK)) i_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_bits (set_bits),
        .clr_we   (clr_we),
        .clr_bits (clr_bits),
        .mask     (irq_mask),
        .status   (status),
        .irq      (irq)
    );

endmodule

// File: rtl/chst_checker.sv
// Module: chst_checker
// Property checks on the tracker's ports, attached by bind.
module chst_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] cfg_type,
    input logic       cfg_tx,
    input logic       cfg_flow_en,
    input logic       cmd_valid,
    input logic [7:0] cmd_byte,
    input logic       clr_we,
    input logic [6:0] irq_mask,
    input logic [6:0] status,
    input logic       irq
);

    // R10: without a clear write no set bit drops
    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_we |=> ((status & $past(status)) == $past(status)));

    // R3: host error bit forces the interrupt on the next edge
    p_host_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
        status[1] |=> irq);

    // R11: no enabled bit and no host error means no interrupt next edge
    p_irq_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (((status & irq_mask) == 7'd0) && !status[1]) |=> !irq);

    // R2: flow control enabled keeps buffer error clear
    p_buf_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_flow_en && !status[0]) |=> !status[0]);

    // R4: non-synchronous channels never set frame-sync lost
    p_sync_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg_type != 2'd0) && !status[2]) |=> !status[2]);

    // R5: async start on an async RX channel sets packet start
    p_start_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_byte == 8'h20 && cfg_type == 2'd2 && !cfg_tx) |=> status[4]);

    // R5: TX channels never set packet start
    p_tx_nostart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_tx && !status[4]) |=> !status[4]);

endmodule

bind chan_status_tracker chst_checker i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_type    (cfg_type),
    .cfg_tx      (cfg_tx),
    .cfg_flow_en (cfg_flow_en),
    .cmd_valid   (cmd_valid),
    .cmd_byte    (cmd_byte),
    .clr_we      (clr_we),
    .irq_mask    (irq_mask),
    .status      (status),
    .irq         (irq)
);

// File: tb/test_chan_status_tracker.sv
`timescale 1ns/1ps
module test_chan_status_tracker;

    localparam time TCLK = 20ns;
    localparam int  NV   = 22;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] cfg_type;
    logic       cfg_tx, cfg_flow_en;
    logic       cmd_valid, rsp_valid;
    logic [7:0] cmd_byte, rsp_byte;
    logic       eop, buf_push, buf_pop, buf_full, buf_empty;
    logic       host_err, sync_lost, xmit_perr;
    logic       clr_we;
    logic [6:0] clr_bits, irq_mask, status;
    logic       in_packet, irq;

    int total = 0;
    int bad   = 0;

    always #(TCLK/2) clk = ~clk;

    chan_status_tracker i_chan_status_tracker (
        .clk(clk), .rst_n(rst_n), .cfg_type(cfg_type), .cfg_tx(cfg_tx),
        .cfg_flow_en(cfg_flow_en), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
        .rsp_valid(rsp_valid), .rsp_byte(rsp_byte), .eop(eop),
        .buf_push(buf_push), .buf_pop(buf_pop), .buf_full(buf_full),
        .buf_empty(buf_empty), .host_err(host_err), .sync_lost(sync_lost),
        .xmit_perr(xmit_perr), .clr_we(clr_we), .clr_bits(clr_bits),
        .irq_mask(irq_mask), .status(status), .in_packet(in_packet), .irq(irq)
    );

    // fields: type dir(tx) flow cmdv cmd rspv rsp push pop full empty host sync xpe | expected status
    localparam logic [35:0] VEC [NV] = '{
        {2'd0,1'b1,1'b0,1'b0,8'h00,1'b0,8'h00,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,7'h01}, // R2 tx pop empty
        {2'd0,1'b1,1'b1,1'b0,8'h00,1'b0,8'h00,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,7'h00}, // R2 flow on
        {2'd0,1'b0,1'b0,1'b0,8'h00,1'b0,8'h00,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,7'h01}, // R2 rx push full
        {2'd0,1'b0,1'b0,1'b0,8'h00,1'b0,8'h00,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,7'h00}, // R2 not full
        {2'd2,1'b1,1'b1,1'b0,8'h00,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,7'h02}, // R3 host
        {2'd0,1'b0,1'b0,1'b0,8'h00,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,7'h04}, // R4 sync
        {2'd2,1'b0,1'b0,1'b0,8'h00,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,7'h00}, // R4 async
        {2'd2,1'b0,1'b1,1'b1,8'h20,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,7'h10}, // R5 async start
        {2'd3,1'b0,1'b1,1'b1,8'h30,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,7'h10}, // R5 ctrl start
        {2'd2,1'b1,1'b1,1'b1,8'h20,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,7'h00}, // R5 tx ignores
        {2'd2,1'b0,1'b1,1'b1,8'h26,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,7'h48}, // R6 async break
        {2'd3,1'b0,1'b1,1'b0,8'h00,1'b1,8'h70,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,7'h08}, // R6 rx rsp brk
        {2'd2,1'b0,1'b1,1'b0,8'h00,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,7'h08}, // R6 xperr
        {2'd1,1'b0,1'b1,1'b0,8'h00,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,7'h00}, // R6 iso gate
        {2'd2,1'b1,1'b1,1'b0,8'h00,1'b1,8'h72,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,7'h20}, // R7 tx perr
        {2'd0,1'b1,1'b0,1'b0,8'h00,1'b1,8'h72,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,7'h00}, // R7 sync tx
        {2'd2,1'b0,1'b1,1'b1,8'h30,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,7'h20}, // R7 wrong fam
        {2'd0,1'b0,1'b0,1'b1,8'h20,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,7'h20}, // R7 sync rx
        {2'd1,1'b1,1'b1,1'b0,8'h00,1'b1,8'h70,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,7'h40}, // R8 tx rbrk
        {2'd0,1'b0,1'b0,1'b1,8'h36,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,7'h60}, // R8 sync rx brk
        {2'd3,1'b0,1'b1,1'b1,8'h36,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,7'h48}, // R8 ctrl brk
        {2'd2,1'b0,1'b1,1'b1,8'h55,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,7'h00}  // R5 data byte
    };

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        cmd_valid = 0; cmd_byte = 0; rsp_valid = 0; rsp_byte = 0; eop = 0;
        buf_push = 0; buf_pop = 0; buf_full = 0; buf_empty = 0;
        host_err = 0; sync_lost = 0; xmit_perr = 0; clr_we = 0; clr_bits = 0;
    endtask

    // one cycle: stimulus already driven at negedge, advance to next negedge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // clear all status and close any packet
    task automatic wipe();
        idle();
        clr_we = 1; clr_bits = 7'h7F; eop = 1;
        step();
        idle();
    endtask

    task automatic rx_cmd(input logic [7:0] b);
        cmd_valid = 1; cmd_byte = b;
        step();
        idle();
    endtask

    initial begin
        #(TCLK * 200000);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle();
        cfg_type = 0; cfg_tx = 0; cfg_flow_en = 0; irq_mask = 0;
        rst_n = 0;
        @(negedge clk); @(negedge clk);
        // drive events during reset: must not register
        host_err = 1;
        step();
        check("R1 status", status, 0);
        check("R1 in_packet", in_packet, 0);
        check("R1 irq", irq, 0);
        idle();
        rst_n = 1;
        step();

        // table walk
        for (int i = 0; i < NV; i++) begin
            wipe();
            cfg_type    = VEC[i][35:34];
            cfg_tx      = VEC[i][33];
            cfg_flow_en = VEC[i][32];
            cmd_valid   = VEC[i][31];
            cmd_byte    = VEC[i][30:23];
            rsp_valid   = VEC[i][22];
            rsp_byte    = VEC[i][21:14];
            buf_push    = VEC[i][13];
            buf_pop     = VEC[i][12];
            buf_full    = VEC[i][11];
            buf_empty   = VEC[i][10];
            host_err    = VEC[i][9];
            sync_lost   = VEC[i][8];
            xmit_perr   = VEC[i][7];
            step();
            idle();
            check($sformatf("R12 vector %0d", i), status, VEC[i][6:0]);
        end

        // R9 / R7: second start inside an open packet
        cfg_type = 2; cfg_tx = 0; cfg_flow_en = 1;
        wipe();
        rx_cmd(8'h20);
        check("R9 open", in_packet, 1);
        check("R9 single start no proto", status, 7'h10);
        rx_cmd(8'h20);
        check("R7 restart proto", status, 7'h30);
        check("R9 restart stays open", in_packet, 1);

        // R9: eop closes, later start is clean
        wipe();
        rx_cmd(8'h20);
        eop = 1; step(); idle();
        check("R9 eop closes", in_packet, 0);
        rx_cmd(8'h20);
        check("R9 start after eop", status, 7'h10);

        // R9: break closes
        wipe();
        rx_cmd(8'h20);
        rx_cmd(8'h26);
        check("R9 break closes", in_packet, 0);
        clr_we = 1; clr_bits = 7'h7F; step(); idle();
        rx_cmd(8'h20);
        check("R9 start after break", status, 7'h10);

        // R9: receiver break closes, start same cycle as eop wins
        wipe();
        rx_cmd(8'h20);
        rsp_valid = 1; rsp_byte = 8'h70; step(); idle();
        check("R9 rx rsp break closes", in_packet, 0);
        cmd_valid = 1; cmd_byte = 8'h20; eop = 1; step(); idle();
        check("R9 start beats eop", in_packet, 1);

        // R10: sticky, clear, set beats clear
        wipe();
        host_err = 1; step(); idle();
        step();
        check("R10 sticky", status, 7'h02);
        clr_we = 1; clr_bits = 7'h04; step(); idle();
        check("R10 other clear no effect", status, 7'h02);
        host_err = 1; clr_we = 1; clr_bits = 7'h02; step(); idle();
        check("R10 set beats clear", status, 7'h02);
        clr_we = 1; clr_bits = 7'h02; step(); idle();
        check("R10 w1c", status, 7'h00);

        // R11 / R3: interrupt timing and masking
        cfg_type = 2; cfg_tx = 0; irq_mask = 7'h00;
        wipe(); step();
        rx_cmd(8'h20);
        check("R11 status set", status, 7'h10);
        check("R11 irq lag", irq, 0);
        step();
        check("R11 masked no irq", irq, 0);
        irq_mask = 7'h10; step();
        check("R11 unmasked irq", irq, 1);
        irq_mask = 7'h00; step();
        check("R11 remask", irq, 0);
        wipe(); step();
        host_err = 1; step(); idle();
        check("R3 irq lag", irq, 0);
        step();
        check("R3 unmaskable irq", irq, 1);
        wipe(); step();
        check("R11 cleared irq", irq, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule